// File: doc/BRIEF.md
# Two-Level Interrupt Entry Controller

This block decides, at instruction boundaries, whether a small core must leave its current mode to service a normal interrupt or a fast interrupt. It watches two request lines, the core's combined program-counter and status word, and a strobe that marks an instruction boundary. When it takes an exception it produces a one-cycle take pulse, the new mode, the new values of the two mask bits, the vector address to fetch from, and a write of the return word into the link register of the mode being entered.

The two levels have strict priority. A fast request beats a normal one and can interrupt a running normal handler. A normal request is never taken while the core is in fast mode. Entering fast mode sets both masks. Entering normal mode sets only the normal mask, so fast interrupts stay enabled. A request that arrives while its mask is set is latched and held until it can be taken, even if the request line drops in the meantime. Instruction fetch and the register file are outside this block. The core applies the new mode, the masks and the vector after it sees the take pulse.

Top module: `intr_entry_ctrl`

## Requirements
- R1: Requests are evaluated only on a rising clock edge at which `boundary_i` is 1. A decision made at that edge raises `take_o` for exactly the following cycle.
- R2: If both levels are eligible at a boundary, the fast interrupt is taken (`mode_o` = 2'b01).
- R3: A fast request is taken while the core is in normal interrupt mode (status bits 1:0 = 2'b10), provided the F mask (bit 26) is clear.
- R4: A normal request is never taken while the core is in fast mode (status bits 1:0 = 2'b01), even with the I mask (bit 27) clear.
- R5: Fast entry drives `mode_o` = 2'b01, `imask_o` = 1, `fmask_o` = 1 and `vec_o` = 0x1C.
- R6: Normal entry drives `mode_o` = 2'b10, `imask_o` = 1, `fmask_o` equal to the F bit (bit 26) at the boundary, and `vec_o` = 0x18.
- R7: With every take, `link_we_o` is 1 and `link_data_o` holds the status word present at the boundary. The write targets the bank of the new mode, `mode_o`.
- R8: A request that arrives while its mask bit is set is latched. It is taken at the first boundary after the mask clears, even if the request line has since dropped. The latch is cleared when that level is taken.
- R9: A boundary strobe in the cycle where `take_o` is high is ignored, so a take is never followed directly by another take.
- R10: After reset, `take_o`, `link_we_o`, `mode_o`, `imask_o`, `fmask_o`, `vec_o` and `link_data_o` are all zero. The mode field encodes user as 00, fast as 01, normal as 10 and supervisor as 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_req_i | input | 1 | Normal interrupt request |
| fiq_req_i | input | 1 | Fast interrupt request |
| status_i | input | 32 | Combined word: I mask bit 27, F mask bit 26, PC bits 25:2, mode bits 1:0 |
| boundary_i | input | 1 | Instruction-boundary strobe |
| take_o | output | 1 | One-cycle pulse: exception taken |
| mode_o | output | 2 | New mode |
| imask_o | output | 1 | New I mask |
| fmask_o | output | 1 | New F mask |
| vec_o | output | 32 | Vector address |
| link_we_o | output | 1 | Link register write enable |
| link_data_o | output | 32 | Return word written to the new mode's link register |

## Verification
Each level is requested on its own from user mode, with the F mask both clear and set. This separates the two entry encodings and shows whether F is kept or forced on normal entry. Both requests are then raised together, and each level is requested from the other's handler mode. These patterns tell priority, preemption and the fast-mode block apart. Masked requests that are pulsed and withdrawn, requests without a strobe, and strobes during the take pulse separate pending latch behaviour, boundary gating and back-to-back suppression.

// File: rtl/intr_entry_pkg.sv
package intr_entry_pkg;
  localparam int WORD_W   = 32;
  localparam int BIT_I    = 27;
  localparam int BIT_F    = 26;
  localparam int MODE_W   = 2;
  localparam int NUM_LVL  = 2;
  localparam int LVL_IRQ  = 0;
  localparam int LVL_FIQ  = 1;

  typedef enum logic [MODE_W-1:0] {
    MODE_USR = 2'b00,
    MODE_FIQ = 2'b01,
    MODE_IRQ = 2'b10,
    MODE_SVC = 2'b11
  } mode_e;
endpackage

// File: rtl/intr_pend.sv
module intr_pend #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] act_o
);
  logic [N-1:0] pend_q;

  for (genvar g = 0; g < N; g++) begin : g_lvl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q[g] <= 1'b0;
      else         pend_q[g] <= (pend_q[g] | req_i[g]) & ~clr_i[g];
    end
    assign act_o[g] = pend_q[g] | req_i[g];
  end
endmodule

// File: rtl/intr_arb.sv
module intr_arb
  import intr_entry_pkg::*;
(
  input  logic [NUM_LVL-1:0] act_i,
  input  logic               boundary_i,
  input  logic               busy_i,
  input  logic               imask_i,
  input  logic               fmask_i,
  input  logic [MODE_W-1:0]  mode_i,
  output logic [NUM_LVL-1:0] grant_o
);
  logic fiq_ok, irq_ok, open_win;

  always_comb begin
    open_win = boundary_i & ~busy_i;
    fiq_ok   = act_i[LVL_FIQ] & ~fmask_i;
    // normal level is shut out of the fast handler regardless of I
    irq_ok   = act_i[LVL_IRQ] & ~imask_i & (mode_i != MODE_FIQ);
    grant_o  = '0;
    if (open_win) begin
      if (fiq_ok)      grant_o[LVL_FIQ] = 1'b1;
      else if (irq_ok) grant_o[LVL_IRQ] = 1'b1;
    end
  end
endmodule

// File: rtl/intr_entry.sv
module intr_entry
  import intr_entry_pkg::*;
#(
  parameter logic [WORD_W-1:0] IRQ_VEC = 32'h18,
  parameter logic [WORD_W-1:0] FIQ_VEC = 32'h1C
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_LVL-1:0] grant_i,
  input  logic [WORD_W-1:0]  status_i,
  output logic               take_o,
  output logic [MODE_W-1:0]  mode_o,
  output logic               imask_o,
  output logic               fmask_o,
  output logic [WORD_W-1:0]  vec_o,
  output logic [WORD_W-1:0]  link_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_o  <= 1'b0;
      mode_o  <= '0;
      imask_o <= 1'b0;
      fmask_o <= 1'b0;
      vec_o   <= '0;
      link_o  <= '0;
    end else begin
      take_o <= |grant_i;
      if (grant_i[LVL_FIQ]) begin
        mode_o  <= MODE_FIQ;
        imask_o <= 1'b1;
        fmask_o <= 1'b1;
        vec_o   <= FIQ_VEC;
        link_o  <= status_i;
      end else if (grant_i[LVL_IRQ]) begin
        mode_o  <= MODE_IRQ;
        imask_o <= 1'b1;
        fmask_o <= status_i[BIT_F];
        vec_o   <= IRQ_VEC;
        link_o  <= status_i;
      end
    end
  end
endmodule

// File: rtl/intr_entry_ctrl.sv
module intr_entry_ctrl
  import intr_entry_pkg::*;
#(
  parameter logic [WORD_W-1:0] IRQ_VEC = 32'h18,
  parameter logic [WORD_W-1:0] FIQ_VEC = 32'h1C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_req_i,
  input  logic              fiq_req_i,
  input  logic [WORD_W-1:0] status_i,
  input  logic              boundary_i,
  output logic              take_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              imask_o,
  output logic              fmask_o,
  output logic [WORD_W-1:0] vec_o,
  output logic              link_we_o,
  output logic [WORD_W-1:0] link_data_o
);
  logic [NUM_LVL-1:0] req, act, grant;

  assign req[LVL_IRQ] = irq_req_i;
  assign req[LVL_FIQ] = fiq_req_i;

  intr_pend #(.N(NUM_LVL)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .clr_i  (grant),
    .act_o  (act)
  );

  intr_arb u_arb (
    .act_i      (act),
    .boundary_i (boundary_i),
    .busy_i     (take_o),
    .imask_i    (status_i[BIT_I]),
    .fmask_i    (status_i[BIT_F]),
    .mode_i     (status_i[MODE_W-1:0]),
    .grant_o    (grant)
  );

  intr_entry #(.IRQ_VEC(IRQ_VEC), .FIQ_VEC(FIQ_VEC)) u_entry (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .grant_i  (grant),
    .status_i (status_i),
    .take_o   (take_o),
    .mode_o   (mode_o),
    .imask_o  (imask_o),
    .fmask_o  (fmask_o),
    .vec_o    (vec_o),
    .link_o   (link_data_o)
  );

  assign link_we_o = take_o;
endmodule

// File: rtl/intr_entry_ctrl_chk.sv
module intr_entry_ctrl_chk
  import intr_entry_pkg::*;
#(
  parameter logic [WORD_W-1:0] IRQ_VEC = 32'h18,
  parameter logic [WORD_W-1:0] FIQ_VEC = 32'h1C
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fiq_req_i,
  input logic [WORD_W-1:0] status_i,
  input logic              boundary_i,
  input logic              take_o,
  input logic [MODE_W-1:0] mode_o,
  input logic              imask_o,
  input logic              fmask_o,
  input logic [WORD_W-1:0] vec_o,
  input logic              link_we_o,
  input logic [WORD_W-1:0] link_data_o
);
  // R1
  take_after_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(boundary_i));

  // R9
  no_back_to_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o);

  // R2
  fiq_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && !take_o && fiq_req_i && !status_i[BIT_F]) |=> (take_o && mode_o == MODE_FIQ));

  // R4
  no_irq_in_fiq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && mode_o == MODE_IRQ) |-> ($past(status_i[MODE_W-1:0]) != MODE_FIQ));

  // R5
  fiq_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && mode_o == MODE_FIQ) |-> (imask_o && fmask_o && vec_o == FIQ_VEC));

  // R6
  irq_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && mode_o == MODE_IRQ) |-> (imask_o && fmask_o == $past(status_i[BIT_F]) && vec_o == IRQ_VEC));

  // R7
  link_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (link_we_o && link_data_o == $past(status_i)));
endmodule

bind intr_entry_ctrl intr_entry_ctrl_chk #(.IRQ_VEC(IRQ_VEC), .FIQ_VEC(FIQ_VEC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fiq_req_i   (fiq_req_i),
  .status_i    (status_i),
  .boundary_i  (boundary_i),
  .take_o      (take_o),
  .mode_o      (mode_o),
  .imask_o     (imask_o),
  .fmask_o     (fmask_o),
  .vec_o       (vec_o),
  .link_we_o   (link_we_o),
  .link_data_o (link_data_o)
);

// File: tb/intr_entry_ctrl_bench.sv
module intr_entry_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_req = 1'b0, fiq_req = 1'b0, bnd = 1'b0;
  logic [31:0] status = '0;
  logic        take, imask, fmask, link_we;
  logic [1:0]  mode;
  logic [31:0] vec, link_data;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  intr_entry_ctrl u_intr_entry_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(irq_req), .fiq_req_i(fiq_req),
    .status_i(status), .boundary_i(bnd), .take_o(take), .mode_o(mode),
    .imask_o(imask), .fmask_o(fmask), .vec_o(vec), .link_we_o(link_we),
    .link_data_o(link_data));

  function automatic logic [31:0] mk(input logic i, input logic f,
                                     input logic [23:0] pc, input logic [1:0] m);
    return {4'h0, i, f, pc, m};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, let one rising edge pass, land at next negedge
  task automatic step(input logic ir, input logic fr, input logic [31:0] st, input logic b);
    irq_req = ir; fiq_req = fr; status = st; bnd = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; irq_req = 0; fiq_req = 0; bnd = 0; status = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R10 take", {31'b0, take}, 0);
    chk("R10 link_we", {31'b0, link_we}, 0);
    chk("R10 mode", {30'b0, mode}, 0);
    chk("R10 masks", {30'b0, imask, fmask}, 0);
    chk("R10 vec", vec, 0);
    chk("R10 link", link_data, 0);
  endtask

  task automatic t_irq_user(input logic f);
    logic [31:0] w = mk(0, f, 24'h12345, 2'b00);
    do_reset();
    step(1, 0, w, 1);
    chk("R1 take", {31'b0, take}, 1);
    chk("R6 mode", {30'b0, mode}, 32'h2);
    chk("R6 imask", {31'b0, imask}, 1);
    chk("R6 fmask kept", {31'b0, fmask}, {31'b0, f});
    chk("R6 vec", vec, 32'h18);
    chk("R7 we", {31'b0, link_we}, 1);
    chk("R7 data", link_data, w);
    step(0, 0, w, 0);
    chk("R1 pulse ends", {31'b0, take}, 0);
  endtask

  task automatic t_fiq_user();
    logic [31:0] w = mk(0, 0, 24'h0ABCD, 2'b00);
    do_reset();
    step(0, 1, w, 1);
    chk("R5 take", {31'b0, take}, 1);
    chk("R5 mode", {30'b0, mode}, 32'h1);
    chk("R5 masks", {30'b0, imask, fmask}, 32'h3);
    chk("R5 vec", vec, 32'h1C);
    chk("R7 data", link_data, w);
  endtask

  task automatic t_both();
    do_reset();
    step(1, 1, mk(0, 0, 24'h00100, 2'b00), 1);
    chk("R2 take", {31'b0, take}, 1);
    chk("R2 fiq chosen", {30'b0, mode}, 32'h1);
  endtask

  task automatic t_preempt();
    logic [31:0] w = mk(1, 0, 24'h00200, 2'b10);
    do_reset();
    step(0, 1, w, 1);
    chk("R3 take", {31'b0, take}, 1);
    chk("R3 mode", {30'b0, mode}, 32'h1);
    chk("R3 link", link_data, w);
  endtask

  task automatic t_no_irq_in_fiq();
    do_reset();
    step(1, 0, mk(0, 0, 24'h00300, 2'b01), 1);
    chk("R4 no take", {31'b0, take}, 0);
    step(1, 0, mk(0, 0, 24'h00300, 2'b01), 1);
    chk("R4 still no take", {31'b0, take}, 0);
  endtask

  task automatic t_masked_pending();
    do_reset();
    step(1, 0, mk(1, 0, 24'h00400, 2'b00), 1);
    chk("R8 masked no take", {31'b0, take}, 0);
    step(0, 0, mk(1, 0, 24'h00400, 2'b00), 1);
    chk("R8 still masked", {31'b0, take}, 0);
    step(0, 0, mk(0, 0, 24'h00404, 2'b00), 1);
    chk("R8 taken after unmask", {31'b0, take}, 1);
    chk("R8 mode", {30'b0, mode}, 32'h2);
    step(0, 0, mk(0, 0, 24'h00408, 2'b00), 0);
    step(0, 0, mk(0, 0, 24'h00408, 2'b00), 1);
    chk("R8 latch cleared", {31'b0, take}, 0);
    // fast level held under F mask
    step(0, 1, mk(0, 1, 24'h00500, 2'b00), 1);
    chk("R8 fiq masked", {31'b0, take}, 0);
    step(0, 0, mk(0, 0, 24'h00500, 2'b00), 1);
    chk("R8 fiq after unmask", {30'b0, mode} | {31'b0, take} << 4, 32'h11);
  endtask

  task automatic t_boundary_gate();
    logic [31:0] w = mk(0, 0, 24'h00600, 2'b00);
    do_reset();
    step(1, 0, w, 0);
    chk("R1 no strobe no take", {31'b0, take}, 0);
    step(1, 0, w, 1);
    chk("R1 strobe take", {31'b0, take}, 1);
    step(1, 0, w, 1);
    chk("R9 strobe during take ignored", {31'b0, take}, 0);
    step(1, 0, w, 1);
    chk("R9 next strobe takes", {31'b0, take}, 1);
  endtask

  initial begin
    t_reset();
    t_irq_user(0);
    t_irq_user(1);
    t_fiq_user();
    t_both();
    t_preempt();
    t_no_irq_in_fiq();
    t_masked_pending();
    t_boundary_gate();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule